// File: doc/BRIEF.md
# SMBus Byte-Data Host Engine

This block is a register-mapped SMBus master that runs one byte-data transaction at a time. Software loads a data byte, a transmit-address byte and a command byte, then writes the control register to launch the transfer. The block drives the clock and data wires through open-drain enables, paced by an internal divider. While the transfer runs, software polls the status register. When it completes, software reads the data register to get the byte a read returned.

The transmit-address byte holds the 7-bit slave address in its upper seven bits. Its least significant bit gives the direction. The status register doubles as a semaphore: the first read of it by an agent that does not hold the bus sets an in-use bit, and writing a 1 to that bit hands the bus back. Completion and error flags stay set until software clears them by writing ones, so a caller can use one status read to tell a clean transfer from a NACK or a corrupted bus.

Top module: `smbus_host_engine`

## Requirements
- R1: After reset every register reads 0x00 and both open-drain enables are inactive. They stay inactive whenever host-busy (status bit 0) is clear.
- R2: A status read while the in-use bit (bit 6) is clear returns that bit as 0 and then sets it. Later reads return it as 1 until software writes a 1 to bit 6.
- R3: A control write with bit 6 set and bits 4:2 equal to 010 starts a transaction and sets host-busy until the transaction ends. A control write with any other protocol code, or any control write while busy, starts nothing.
- R4: A write transaction (transmit-address bit 0 = 0) sends START, address with bit 0 = 0, command byte, data register byte, STOP. Each byte is followed by an acknowledge clock.
- R5: A read transaction (transmit-address bit 0 = 1) sends START, address+write, command, a repeated START, address with bit 0 = 1, then clocks in 8 bits MSB first, answers with NACK and sends STOP. The received byte goes to the data register.
- R6: A transaction whose bytes are all acknowledged sets status bit 1. With ownership held, the status then reads 0x42.
- R7: A NACK on any byte sent by the host ends the transfer with STOP and sets bits 2 and 4 (status 0x54 with ownership). A failed read leaves the data register unchanged, and bytes after the NACK are not sent.
- R8: If SDA reads low while the host leaves it released on an address, command or data bit, the host releases both wires at once, sends no STOP, and sets bits 3 and 4 (status 0x58 with ownership).
- R9: Writing ones to status bits 1 to 4 clears those flags, and zeros leave them alone. The host-reset pattern 0xFE clears all flags and ownership, so the status reads 0x00.
- R10: SDA driven by the host changes only while the host holds SCL low, except at START and STOP. Each bit, START, repeated START and STOP makes one SCL rising edge, so a full write gives 29 and a full read gives 39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | 3 | Register offset: 0 status, 2 control, 3 command, 4 transmit address, 5 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Level sensed on the SDA wire |

## Verification
The assertions assume that sda_in is the wired-AND of every driver on SDA, that no slave stretches SCL, and that reg_rd and reg_wr are never asserted in the same cycle. The bench keeps within these limits. It builds the bus as the AND of the host enable, a behavioural slave and an optional jam driver. Its slave changes SDA only on a falling SCL edge. Every register access uses its own pair of half-cycle-aligned strobes, and a bus error is provoked only by holding SDA low across a whole transfer.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_STAT  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CMD   = 3'd3;
  localparam logic [REG_AW-1:0] OFS_XADDR = 3'd4;
  localparam logic [REG_AW-1:0] OFS_DATA0 = 3'd5;

  localparam int ST_BUSY   = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_DEVERR = 2;
  localparam int ST_BUSERR = 3;
  localparam int ST_FAILED = 4;
  localparam int ST_INUSE  = 6;

  localparam int CT_START = 6;
  localparam logic [2:0] PROTO_BYTE_DATA = 3'b010;

  typedef enum logic [1:0] {
    BOP_START,
    BOP_STOP,
    BOP_BIT
  } bop_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_START,
    SQ_ADDRW,
    SQ_CMD,
    SQ_WDATA,
    SQ_RSTART,
    SQ_ADDRR,
    SQ_RDATA,
    SQ_STOP
  } sq_e;
endpackage

// File: rtl/smbus_tick_gen.sv
module smbus_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/smbus_bit_engine.sv
module smbus_bit_engine
  import smbus_host_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cmd_valid,
  input  bop_e cmd_op,
  input  logic cmd_bit,
  input  logic cmd_chk,
  input  logic sda_in,
  output logic busy,
  output logic done,
  output logic rx_bit,
  output logic arb_lost,
  output logic tick_clr,
  output logic scl_oe,
  output logic sda_oe
);
  logic [1:0] phase;
  bop_e       op_q;
  logic       bit_q;
  logic       chk_q;

  assign tick_clr = cmd_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rx_bit   <= 1'b1;
      arb_lost <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      phase    <= 2'd0;
      op_q     <= BOP_STOP;
      bit_q    <= 1'b1;
      chk_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_valid && !busy) begin
        busy     <= 1'b1;
        phase    <= 2'd0;
        op_q     <= cmd_op;
        bit_q    <= cmd_bit;
        chk_q    <= cmd_chk;
        arb_lost <= 1'b0;
        scl_oe   <= 1'b1;
        case (cmd_op)
          BOP_START: sda_oe <= 1'b0;
          BOP_STOP:  sda_oe <= 1'b1;
          default:   sda_oe <= !cmd_bit;
        endcase
      end else if (busy && tick) begin
        phase <= phase + 2'd1;
        case (op_q)
          BOP_START: begin
            if (phase == 2'd0)      scl_oe <= 1'b0;
            else if (phase == 2'd1) sda_oe <= 1'b1;
            else if (phase == 2'd2) scl_oe <= 1'b1;
            else begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
          BOP_STOP: begin
            if (phase == 2'd0)      scl_oe <= 1'b0;
            else if (phase == 2'd1) sda_oe <= 1'b0;
            else if (phase == 2'd3) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
          default: begin
            if (phase == 2'd0) scl_oe <= 1'b0;
            else if (phase == 2'd2) begin
              rx_bit <= sda_in;
              if (chk_q && bit_q && !sda_in) begin
                scl_oe   <= 1'b0;
                sda_oe   <= 1'b0;
                arb_lost <= 1'b1;
                busy     <= 1'b0;
                done     <= 1'b1;
              end else begin
                scl_oe <= 1'b1;
              end
            end else if (phase == 2'd3) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (op_q == BOP_BIT && sda_oe != $past(sda_oe)) |-> (scl_oe && $past(scl_oe)))
    else $error("host SDA moved while SCL released"); // R10
endmodule

// File: rtl/smbus_txn_seq.sv
module smbus_txn_seq
  import smbus_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] xaddr,
  input  logic [7:0] cmd_byte,
  input  logic [7:0] wr_byte,
  input  logic       be_busy,
  input  logic       be_done,
  input  logic       be_rx,
  input  logic       be_arb,
  output logic       cmd_valid,
  output bop_e       cmd_op,
  output logic       cmd_bit,
  output logic       cmd_chk,
  output logic       fin,
  output logic       fin_dev,
  output logic       fin_bus,
  output logic       fin_read,
  output logic [7:0] rx_byte
);
  sq_e        state;
  logic [3:0] idx;
  logic [7:0] a_q, c_q, d_q;
  logic [7:0] tx_byte;
  logic       last_bit;

  assign last_bit = idx[3];
  assign fin_read = a_q[0];

  always_comb begin
    case (state)
      SQ_ADDRW: tx_byte = {a_q[7:1], 1'b0};
      SQ_CMD:   tx_byte = c_q;
      SQ_WDATA: tx_byte = d_q;
      SQ_ADDRR: tx_byte = {a_q[7:1], 1'b1};
      default:  tx_byte = 8'hFF;
    endcase
    if (state == SQ_START || state == SQ_RSTART) cmd_op = BOP_START;
    else if (state == SQ_STOP)                   cmd_op = BOP_STOP;
    else                                         cmd_op = BOP_BIT;
    cmd_bit = last_bit ? 1'b1 : tx_byte[~idx[2:0]];
    cmd_chk = !last_bit && state != SQ_RDATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      idx       <= 4'd0;
      a_q       <= 8'h00;
      c_q       <= 8'h00;
      d_q       <= 8'h00;
      cmd_valid <= 1'b0;
      fin       <= 1'b0;
      fin_dev   <= 1'b0;
      fin_bus   <= 1'b0;
      rx_byte   <= 8'h00;
    end else begin
      cmd_valid <= 1'b0;
      fin       <= 1'b0;
      if (state == SQ_IDLE) begin
        if (start) begin
          a_q       <= xaddr;
          c_q       <= cmd_byte;
          d_q       <= wr_byte;
          fin_dev   <= 1'b0;
          fin_bus   <= 1'b0;
          idx       <= 4'd0;
          state     <= SQ_START;
          cmd_valid <= 1'b1;
        end
      end else if (be_done) begin
        cmd_valid <= 1'b1;
        idx       <= 4'd0;
        if (be_arb) begin
          fin_bus   <= 1'b1;
          fin       <= 1'b1;
          cmd_valid <= 1'b0;
          state     <= SQ_IDLE;
        end else begin
          case (state)
            SQ_START:  state <= SQ_ADDRW;
            SQ_RSTART: state <= SQ_ADDRR;
            SQ_STOP: begin
              fin       <= 1'b1;
              cmd_valid <= 1'b0;
              state     <= SQ_IDLE;
            end
            SQ_RDATA: begin
              if (!last_bit) begin
                rx_byte <= {rx_byte[6:0], be_rx};
                idx     <= idx + 4'd1;
              end else begin
                state <= SQ_STOP;
              end
            end
            default: begin
              if (!last_bit) begin
                idx <= idx + 4'd1;
              end else if (be_rx) begin
                fin_dev <= 1'b1;
                state   <= SQ_STOP;
              end else begin
                case (state)
                  SQ_ADDRW: state <= SQ_CMD;
                  SQ_CMD:   state <= a_q[0] ? SQ_RSTART : SQ_WDATA;
                  SQ_ADDRR: state <= SQ_RDATA;
                  default:  state <= SQ_STOP;
                endcase
              end
            end
          endcase
        end
      end
    end
  end

  AST_CMD_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !be_busy)
    else $error("command issued to a busy bit engine"); // R4
endmodule

// File: rtl/smbus_host_engine.sv
module smbus_host_engine
  import smbus_host_pkg::*;
#(
  parameter int CLK_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SS-1:0] sda_sync;
  logic          sda_s;

  logic       busy, f_done, f_dev, f_bus, f_fail, in_use;
  logic [7:0] ctrl_q, cmd_q, xaddr_q, data0_q;
  logic       start_p;
  logic [7:0] status;

  logic       tick, tick_clr;
  logic       be_valid, be_bit, be_chk, be_busy, be_done, be_rx, be_arb;
  bop_e       be_op;
  logic       seq_fin, seq_dev, seq_bus, seq_read;
  logic [7:0] seq_rx;

  always_ff @(posedge clk) begin
    if (rst) sda_sync <= '1;
    else     sda_sync <= {sda_sync[SS-2:0], sda_in};
  end
  assign sda_s = sda_sync[SS-1];

  assign status = {1'b0, in_use, 1'b0, f_fail, f_bus, f_dev, f_done, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      f_done    <= 1'b0;
      f_dev     <= 1'b0;
      f_bus     <= 1'b0;
      f_fail    <= 1'b0;
      in_use    <= 1'b0;
      ctrl_q    <= 8'h00;
      cmd_q     <= 8'h00;
      xaddr_q   <= 8'h00;
      data0_q   <= 8'h00;
      start_p   <= 1'b0;
      reg_rdata <= 8'h00;
    end else begin
      start_p <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          OFS_STAT: begin
            if (reg_wdata[ST_DONE])   f_done <= 1'b0;
            if (reg_wdata[ST_DEVERR]) f_dev  <= 1'b0;
            if (reg_wdata[ST_BUSERR]) f_bus  <= 1'b0;
            if (reg_wdata[ST_FAILED]) f_fail <= 1'b0;
            if (reg_wdata[ST_INUSE])  in_use <= 1'b0;
          end
          OFS_CTRL: begin
            ctrl_q <= reg_wdata & ~(8'h01 << CT_START);
            if (reg_wdata[CT_START] && reg_wdata[4:2] == PROTO_BYTE_DATA && !busy) begin
              busy    <= 1'b1;
              start_p <= 1'b1;
            end
          end
          OFS_CMD:   cmd_q   <= reg_wdata;
          OFS_XADDR: xaddr_q <= reg_wdata;
          OFS_DATA0: data0_q <= reg_wdata;
          default: ;
        endcase
      end
      if (seq_fin) begin
        busy <= 1'b0;
        if (seq_bus) begin
          f_bus  <= 1'b1;
          f_fail <= 1'b1;
        end else if (seq_dev) begin
          f_dev  <= 1'b1;
          f_fail <= 1'b1;
        end else begin
          f_done <= 1'b1;
          if (seq_read) data0_q <= seq_rx;
        end
      end
      if (reg_rd) begin
        case (reg_addr)
          OFS_STAT:  reg_rdata <= status;
          OFS_CTRL:  reg_rdata <= ctrl_q;
          OFS_CMD:   reg_rdata <= cmd_q;
          OFS_XADDR: reg_rdata <= xaddr_q;
          OFS_DATA0: reg_rdata <= data0_q;
          default:   reg_rdata <= 8'h00;
        endcase
        if (reg_addr == OFS_STAT && !reg_wr) in_use <= 1'b1;
      end
    end
  end

  smbus_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (tick_clr),
    .tick (tick)
  );

  smbus_bit_engine u_bit (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmd_valid (be_valid),
    .cmd_op    (be_op),
    .cmd_bit   (be_bit),
    .cmd_chk   (be_chk),
    .sda_in    (sda_s),
    .busy      (be_busy),
    .done      (be_done),
    .rx_bit    (be_rx),
    .arb_lost  (be_arb),
    .tick_clr  (tick_clr),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  smbus_txn_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_p),
    .xaddr     (xaddr_q),
    .cmd_byte  (cmd_q),
    .wr_byte   (data0_q),
    .be_busy   (be_busy),
    .be_done   (be_done),
    .be_rx     (be_rx),
    .be_arb    (be_arb),
    .cmd_valid (be_valid),
    .cmd_op    (be_op),
    .cmd_bit   (be_bit),
    .cmd_chk   (be_chk),
    .fin       (seq_fin),
    .fin_dev   (seq_dev),
    .fin_bus   (seq_bus),
    .fin_read  (seq_read),
    .rx_byte   (seq_rx)
  );

  AST_IDLE_LINES_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe))
    else $error("bus driven while idle"); // R1
  AST_BUSY_UNTIL_FIN: assert property (@(posedge clk) disable iff (rst)
    (busy && !seq_fin) |=> busy)
    else $error("busy dropped early"); // R3
  AST_BUSERR_RELEASED: assert property (@(posedge clk) disable iff (rst)
    $rose(f_bus) |-> (!scl_oe && !sda_oe))
    else $error("bus held after bus error"); // R8
  AST_DEVERR_FAILS: assert property (@(posedge clk) disable iff (rst)
    $rose(f_dev) |-> f_fail)
    else $error("device error without failed flag"); // R7
endmodule

// File: tb/tb_smbus_host_engine.sv
`timescale 1ns/1ps
module tb_smbus_host_engine;
  localparam int DIV = 4;
  localparam logic [6:0] SLV = 7'h50;
  localparam int SI = 0, SRX = 1, SACK = 2, STX = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe;
  logic       s_drv, jam = 1'b0, nack_cmd = 1'b0, nack_data = 1'b0;

  wire bus_scl = !scl_oe;
  wire bus_sda = !(sda_oe || s_drv || jam);

  smbus_host_engine #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(bus_sda)
  );

  // behavioural slave
  logic [7:0] mem [16];
  int         s_state, s_cnt, s_idx;
  logic [7:0] s_sh;
  logic [3:0] s_ptr;
  logic       s_rw, p_scl, p_sda, q_scl;
  int         s_starts, rises;

  always @(posedge clk) begin
    if (rst) begin
      s_state <= SI; s_cnt <= 0; s_idx <= 0; s_sh <= 8'h00; s_ptr <= 4'd0;
      s_rw <= 1'b0; s_drv <= 1'b0; p_scl <= 1'b1; p_sda <= 1'b1; s_starts <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= (i == 7) ? 8'h3C : 8'h00;
    end else begin
      p_scl <= bus_scl;
      p_sda <= bus_sda;
      if (p_scl && bus_scl && p_sda && !bus_sda) begin
        s_state <= SRX; s_cnt <= 0; s_idx <= 0; s_drv <= 1'b0; s_starts <= s_starts + 1;
      end else if (p_scl && bus_scl && !p_sda && bus_sda) begin
        s_state <= SI; s_drv <= 1'b0;
      end else if (!p_scl && bus_scl) begin
        if (s_state == SRX) begin
          s_sh  <= {s_sh[6:0], bus_sda};
          s_cnt <= s_cnt + 1;
        end
      end else if (p_scl && !bus_scl) begin
        if (s_state == SRX && s_cnt == 8) begin
          if (s_idx == 0) begin
            if (s_sh[7:1] == SLV) begin
              s_rw <= s_sh[0]; s_drv <= 1'b1; s_state <= SACK;
            end else s_state <= SI;
          end else if (s_idx == 1) begin
            s_ptr <= s_sh[3:0];
            if (nack_cmd) s_state <= SI;
            else begin s_drv <= 1'b1; s_state <= SACK; end
          end else begin
            if (nack_data) s_state <= SI;
            else begin
              mem[s_ptr] <= s_sh; s_ptr <= s_ptr + 4'd1;
              s_drv <= 1'b1; s_state <= SACK;
            end
          end
        end else if (s_state == SACK) begin
          s_idx <= s_idx + 1;
          if (s_idx == 0 && s_rw) begin
            s_state <= STX; s_sh <= mem[s_ptr]; s_drv <= !mem[s_ptr][7]; s_cnt <= 1;
          end else begin
            s_state <= SRX; s_drv <= 1'b0; s_cnt <= 0;
          end
        end else if (s_state == STX) begin
          if (s_cnt == 8) begin
            s_drv <= 1'b0; s_state <= SI;
          end else begin
            s_drv <= !s_sh[7 - s_cnt]; s_cnt <= s_cnt + 1;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    if (rst) begin rises <= 0; q_scl <= 1'b1; end
    else begin
      q_scl <= bus_scl;
      if (!q_scl && bus_scl) rises <= rises + 1;
    end
  end

  // scoreboard
  typedef struct { string req; logic [7:0] exp; } item_t;
  item_t      sb_q[$];
  logic [7:0] obs_val;
  event       obs_ev;
  int         checks = 0, errors = 0;

  initial forever begin
    @(obs_ev);
    if (sb_q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard: actual %02h with no expected item", obs_val);
    end else begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (obs_val !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", it.req, obs_val, it.exp);
      end
    end
  end

  task automatic push_exp(input string req, input logic [7:0] e);
    item_t it;
    it.req = req; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_val = v;
    ->obs_ev;
    @(posedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] e);
    push_exp(req, e);
    observe(act);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(3'd0, s);
      if (!s[0]) return;
    end
  endtask

  task automatic run(input logic [7:0] xa, input logic [7:0] cmd, input logic [7:0] d0);
    wr(3'd5, d0); wr(3'd4, xa); wr(3'd3, cmd); wr(3'd2, 8'h48);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int st0, r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    rd(3'd0, v); chk("R1 status after reset", v, 8'h00);
    rd(3'd5, v); chk("R1 data after reset", v, 8'h00);
    chk("R1 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
    rd(3'd0, v); chk("R2 ownership granted", v, 8'h40);

    // R4 write transaction, extra start while busy ignored (R3)
    st0 = s_starts; r0 = rises;
    run({SLV, 1'b0}, 8'h03, 8'hA5);
    rd(3'd0, v); chk("R3 busy during transfer", v, 8'h41);
    wr(3'd2, 8'h48);
    wait_idle();
    rd(3'd0, v); chk("R6 write success status", v, 8'h42);
    chk("R4 slave received data", mem[3], 8'hA5);
    chk("R3 second start ignored", 8'(s_starts - st0), 8'd1);
    chk("R10 write scl edges", 8'(rises - r0), 8'd29);

    wr(3'd0, 8'h02);
    rd(3'd0, v); chk("R9 w1c done", v, 8'h40);

    // R5 read transactions
    st0 = s_starts; r0 = rises;
    run({SLV, 1'b1}, 8'h03, 8'h00);
    wait_idle();
    rd(3'd0, v); chk("R6 read success status", v, 8'h42);
    rd(3'd5, v); chk("R5 read data", v, 8'hA5);
    chk("R5 repeated start", 8'(s_starts - st0), 8'd2);
    chk("R10 read scl edges", 8'(rises - r0), 8'd39);
    wr(3'd0, 8'h1E);
    run({SLV, 1'b1}, 8'h07, 8'h11);
    wait_idle();
    rd(3'd5, v); chk("R5 read second location", v, 8'h3C);
    wr(3'd0, 8'h1E);

    // R7 NACK on address
    r0 = rises;
    run({7'h31, 1'b0}, 8'h02, 8'h77);
    wait_idle();
    rd(3'd0, v); chk("R7 address nack status", v, 8'h54);
    chk("R7 abort after address", 8'(rises - r0), 8'd11);
    chk("R7 nothing written", mem[2], 8'h00);
    wr(3'd0, 8'h1E);

    // R7 NACK on data
    nack_data = 1'b1;
    run({SLV, 1'b0}, 8'h05, 8'h99);
    wait_idle();
    rd(3'd0, v); chk("R7 data nack status", v, 8'h54);
    chk("R7 data not stored", mem[5], 8'h00);
    nack_data = 1'b0;
    wr(3'd0, 8'h1E);

    // R7 NACK on command of a read: data register kept
    nack_cmd = 1'b1;
    run({SLV, 1'b1}, 8'h07, 8'h5A);
    wait_idle();
    rd(3'd0, v); chk("R7 command nack status", v, 8'h54);
    rd(3'd5, v); chk("R7 data register kept", v, 8'h5A);
    nack_cmd = 1'b0;
    wr(3'd0, 8'h1E);

    // R8 bus error
    jam = 1'b1;
    st0 = s_starts;
    run({SLV, 1'b0}, 8'h04, 8'h66);
    wait_idle();
    rd(3'd0, v); chk("R8 bus error status", v, 8'h58);
    chk("R8 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
    jam = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 slave saw nothing", mem[4], 8'h00);
    wr(3'd0, 8'h1E);

    // R3 unsupported protocol ignored
    r0 = rises;
    wr(3'd2, 8'h44);
    repeat (100) @(negedge clk);
    rd(3'd0, v); chk("R3 other protocol not started", v, 8'h40);
    chk("R3 no bus activity", 8'(rises - r0), 8'd0);

    // R9 host reset pattern, then R2 re-grant
    run({SLV, 1'b0}, 8'h08, 8'h12);
    wait_idle();
    wr(3'd0, 8'hFE);
    rd(3'd0, v); chk("R9 host reset clears all", v, 8'h00);
    rd(3'd0, v); chk("R2 ownership re-granted", v, 8'h40);
    chk("R4 second write stored", mem[8], 8'h12);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule